// File: doc/BRIEF.md
# Dual-Channel Disk Interrupt and Register Decoder

This block sits behind a simple byte-wide memory-mapped bus on an expansion card that carries two disk channels of the ATA style. It decodes host reads and writes into a handful of card-level functions. These are a per-channel interrupt-enable latch, per-channel raw interrupt status, a control byte that opens the extended address window and steers the DMA signals, and a card identity code of four bits that the host reads one bit per location. It also produces chip selects for each channel's task-file and alternate-status registers, so that the drive-side logic does not need its own address decoding.

The enable latches respond to the kind of access and not to the data. Any write to a channel's enable location arms that channel, and a read of the same location disarms it. Each channel's host interrupt is its drive request gated by its latch. A card-wide pending output reports whether either drive is requesting, whatever the latches hold. All outputs are registered. Read data appears on the cycle after the read strobe and returns to zero otherwise.

Top module: `ide_irq_decoder`

## Requirements
- R1: A write with any data to 0x2200 arms the channel-0 enable latch, and a write to 0x3200 arms the channel-1 latch.
- R2: A read of 0x2200 disarms the channel-0 latch and a read of 0x3200 disarms the channel-1 latch. Such a read returns 0x00.
- R3: `host_irq[c]` is the drive request `drv_irq[c]` ANDed with that channel's latch, registered once. An arming write at edge k makes the output follow the request from edge k+1.
- R4: Bit 0 of a read at 0x2290 (channel 0) or 0x3290 (channel 1) is the raw drive request, whatever the latch holds. Bits 7..1 read as 0.
- R5: `card_irq` is the OR of both raw drive requests, registered once.
- R6: A read at 0x2280 + 4*i (i = 0..3) returns type bit i of the card identity in bit 0 and zeros above it. With the default identity 3, the four reads return 1, 1, 0, 0.
- R7: The control byte at offset 0 is written whole and reads back whole. Bit 5 drives `win_en`. Bit 0 drives `dma_sel`, where 1 steers DMA to channel 1 and 0 steers it to channel 0. Writing 0x00 clears both outputs.
- R8: An access to channel base + (n << 6), with n from 0 to 7 and the bases 0x2000 and 0x3000, pulses `tf_cs[c]` for one cycle on the next edge, with `tf_reg` = n.
- R9: An access to 0x2380 or 0x3380 pulses `alt_cs[0]` or `alt_cs[1]` for one cycle on the next edge.
- R10: After reset both latches are disarmed, the control byte is 0x00, and every output is low.
- R11: An access to an unmapped location (for example 0x2010 or 0x2204) raises no chip select, changes no latch and reads 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 14 | Byte address of the access |
| bus_wr | input | 1 | Write strobe, one cycle |
| bus_rd | input | 1 | Read strobe, one cycle |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, valid the cycle after `bus_rd` |
| drv_irq | input | 2 | Raw interrupt request from each drive |
| host_irq | output | 2 | Gated interrupt per channel |
| card_irq | output | 1 | Either drive requesting |
| win_en | output | 1 | Extended address window enable |
| dma_sel | output | 1 | DMA steering: 1 selects channel 1 |
| tf_cs | output | 2 | Task-file chip select per channel |
| tf_reg | output | 3 | Task-file register index for `tf_cs` |
| alt_cs | output | 2 | Alternate-status chip select per channel |

## Verification
The bench builds the block with its default parameters: two channels, a 14-bit address, a register step of 64 bytes and identity code 3. With these values both channel windows and the split identity bits fall inside the address space, and a wrong bit order shows up as a 1/0 pattern that does not match. The bench arms and disarms each channel by access type alone and uses varied write data. It checks that the raw status and the card-wide pending output ignore the latch, while the gated outputs follow it. Misaligned and near-miss addresses check that no select or latch reacts to them.

// File: rtl/ide_irq_pkg.sv
package ide_irq_pkg;
  localparam int BYTE_W = 8;
  typedef logic [BYTE_W-1:0] byte_t;

  // place a single flag in bit 0 of a read byte
  function automatic byte_t flag_byte(input logic f);
    return {{(BYTE_W-1){1'b0}}, f};
  endfunction
endpackage

// File: rtl/ide_irq_decode.sv
module ide_irq_decode #(
  parameter int ADDR_W    = 14,
  parameter int NCH       = 2,
  parameter int TF_BASE   = 'h2000,
  parameter int CH_STRIDE = 'h1000,
  parameter int REG_STEP  = 6,
  parameter int NREG      = 8,
  parameter int IEN_OFS   = 'h200,
  parameter int STAT_OFS  = 'h290,
  parameter int ALT_OFS   = 'h380,
  parameter int ID_OFS    = 'h280,
  parameter int ID_BITS   = 4,
  parameter int ID_STRIDE = 4,
  parameter int CTRL_OFS  = 0
) (
  input  logic [ADDR_W-1:0]          addr,
  output logic [NCH-1:0]             ien_hit,
  output logic [NCH-1:0]             stat_hit,
  output logic [NCH-1:0]             alt_hit,
  output logic [NCH-1:0]             tf_hit,
  output logic                       ctrl_hit,
  output logic                       id_hit,
  output logic [$clog2(ID_BITS)-1:0] id_sel,
  output logic [$clog2(NREG)-1:0]    tf_sel
);
  localparam int IDW  = $clog2(ID_BITS);
  localparam int SELW = $clog2(NREG);
  localparam int TF_SPAN = NREG << REG_STEP;

  assign ctrl_hit = (addr == ADDR_W'(CTRL_OFS));
  // channel bases are aligned well above the register field
  assign tf_sel = addr[REG_STEP +: SELW];

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    localparam int CHB = TF_BASE + c * CH_STRIDE;
    logic [ADDR_W-1:0] off;
    assign off         = addr - ADDR_W'(CHB);
    assign tf_hit[c]   = (addr >= ADDR_W'(CHB)) && (off < ADDR_W'(TF_SPAN)) &&
                         (off[REG_STEP-1:0] == '0);
    assign ien_hit[c]  = (addr == ADDR_W'(CHB + IEN_OFS));
    assign stat_hit[c] = (addr == ADDR_W'(CHB + STAT_OFS));
    assign alt_hit[c]  = (addr == ADDR_W'(CHB + ALT_OFS));
  end

  always_comb begin
    id_hit = 1'b0;
    id_sel = '0;
    for (int i = 0; i < ID_BITS; i++) begin
      if (addr == ADDR_W'(TF_BASE + ID_OFS + i * ID_STRIDE)) begin
        id_hit = 1'b1;
        id_sel = IDW'(i);
      end
    end
  end
endmodule

// File: rtl/ide_irq_channel.sv
module ide_irq_channel (
  input  logic clk,
  input  logic rst,
  input  logic arm,
  input  logic disarm,
  input  logic req,
  output logic irq_o
);
  logic en_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      en_q  <= 1'b0;
      irq_o <= 1'b0;
    end else begin
      if (arm)         en_q <= 1'b1;
      else if (disarm) en_q <= 1'b0;
      irq_o <= req & en_q;
    end
  end

  // R2: a lone disarming read leaves the latch cleared
  p_disarm_r2: assert property (@(posedge clk) disable iff (rst)
    (disarm && !arm) |=> !en_q);
  // R3: the gated output never rises without a request
  p_gate_r3: assert property (@(posedge clk) disable iff (rst)
    irq_o |-> $past(req));
endmodule

// File: rtl/ide_irq_ctrl.sv
module ide_irq_ctrl import ide_irq_pkg::*; #(
  parameter int WIN_BIT   = 5,
  parameter int ROUTE_BIT = 0
) (
  input  logic  clk,
  input  logic  rst,
  input  logic  wr_en,
  input  byte_t wdata,
  output byte_t ctrl_q,
  output logic  win_en,
  output logic  dma_sel
);
  always_ff @(posedge clk) begin
    if (rst)        ctrl_q <= '0;
    else if (wr_en) ctrl_q <= wdata;
  end

  assign win_en  = ctrl_q[WIN_BIT];
  assign dma_sel = ctrl_q[ROUTE_BIT];

  // R7: writing zero clears both steering outputs
  p_clear_r7: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wdata == '0) |=> (!win_en && !dma_sel));
endmodule

// File: rtl/ide_irq_decoder.sv
module ide_irq_decoder import ide_irq_pkg::*; #(
  parameter int              ADDR_W  = 14,
  parameter int              NCH     = 2,
  parameter int              NREG    = 8,
  parameter int              ID_BITS = 4,
  parameter logic [ID_BITS-1:0] CARD_ID = 4'd3
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic [ADDR_W-1:0]       bus_addr,
  input  logic                    bus_wr,
  input  logic                    bus_rd,
  input  logic [BYTE_W-1:0]       bus_wdata,
  output logic [BYTE_W-1:0]       bus_rdata,
  input  logic [NCH-1:0]          drv_irq,
  output logic [NCH-1:0]          host_irq,
  output logic                    card_irq,
  output logic                    win_en,
  output logic                    dma_sel,
  output logic [NCH-1:0]          tf_cs,
  output logic [$clog2(NREG)-1:0] tf_reg,
  output logic [NCH-1:0]          alt_cs
);
  localparam int IDW  = $clog2(ID_BITS);
  localparam int SELW = $clog2(NREG);

  logic [NCH-1:0]  ien_hit, stat_hit, alt_hit, tf_hit;
  logic            ctrl_hit, id_hit;
  logic [IDW-1:0]  id_sel;
  logic [SELW-1:0] tf_sel;
  logic            acc;
  byte_t           ctrl_q, rd_mux;

  assign acc = bus_rd | bus_wr;

  ide_irq_decode #(.ADDR_W(ADDR_W), .NCH(NCH), .NREG(NREG), .ID_BITS(ID_BITS)) u_dec (
    .addr(bus_addr), .ien_hit(ien_hit), .stat_hit(stat_hit), .alt_hit(alt_hit),
    .tf_hit(tf_hit), .ctrl_hit(ctrl_hit), .id_hit(id_hit), .id_sel(id_sel),
    .tf_sel(tf_sel));

  for (genvar c = 0; c < NCH; c++) begin : g_irq
    ide_irq_channel u_ch (
      .clk(clk), .rst(rst),
      .arm(bus_wr & ien_hit[c]),
      .disarm(bus_rd & ien_hit[c]),
      .req(drv_irq[c]),
      .irq_o(host_irq[c]));
  end

  ide_irq_ctrl u_ctrl (
    .clk(clk), .rst(rst), .wr_en(bus_wr & ctrl_hit), .wdata(bus_wdata),
    .ctrl_q(ctrl_q), .win_en(win_en), .dma_sel(dma_sel));

  always_comb begin
    rd_mux = '0;
    if (ctrl_hit) rd_mux = ctrl_q;
    if (id_hit)   rd_mux = flag_byte(CARD_ID[id_sel]);
    for (int c = 0; c < NCH; c++)
      if (stat_hit[c]) rd_mux = flag_byte(drv_irq[c]);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_rdata <= '0;
      card_irq  <= 1'b0;
      tf_cs     <= '0;
      tf_reg    <= '0;
      alt_cs    <= '0;
    end else begin
      bus_rdata <= bus_rd ? rd_mux : '0;
      card_irq  <= |drv_irq;
      tf_cs     <= acc ? tf_hit : '0;
      tf_reg    <= tf_sel;
      alt_cs    <= acc ? alt_hit : '0;
    end
  end

  // R5: card pending only follows a raw request
  p_card_r5: assert property (@(posedge clk) disable iff (rst)
    card_irq |-> $past(|drv_irq));
  // R8: at most one chip select at a time
  p_cs_excl_r8: assert property (@(posedge clk) disable iff (rst)
    $onehot0({tf_cs, alt_cs}));
  // R11: read data is zero unless a read was made
  p_rd_quiet_r11: assert property (@(posedge clk) disable iff (rst)
    !$past(bus_rd) |-> (bus_rdata == '0));
  // R9: an alternate select needs an access in the cycle before
  p_alt_acc_r9: assert property (@(posedge clk) disable iff (rst)
    (|alt_cs) |-> $past(acc));
endmodule

// File: tb/test_ide_irq_decoder.sv
module test_ide_irq_decoder;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [13:0] bus_addr = '0;
  logic        bus_wr = 1'b0, bus_rd = 1'b0;
  logic [7:0]  bus_wdata = '0;
  logic [7:0]  bus_rdata;
  logic [1:0]  drv_irq = '0;
  logic [1:0]  host_irq;
  logic        card_irq, win_en, dma_sel;
  logic [1:0]  tf_cs, alt_cs;
  logic [2:0]  tf_reg;

  int checks = 0, fails = 0;
  bit done = 0;
  logic rd_d = 1'b0;
  logic [7:0] exp_q[$];
  string      tag_q[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  ide_irq_decoder i_ide_irq_decoder (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .drv_irq(drv_irq),
    .host_irq(host_irq), .card_irq(card_irq), .win_en(win_en), .dma_sel(dma_sel),
    .tf_cs(tf_cs), .tf_reg(tf_reg), .alt_cs(alt_cs));

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  // monitor: read data arrives the cycle after the strobe
  always @(posedge clk) rd_d <= bus_rd;
  always @(negedge clk) begin
    if (rd_d) begin
      if (exp_q.size() == 0) check("scoreboard empty", 1, 0);
      else check(tag_q.pop_front(), {24'b0, bus_rdata}, {24'b0, exp_q.pop_front()});
    end
  end

  task automatic wr(input logic [13:0] a, input logic [7:0] d);
    @(negedge clk); bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk); bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [13:0] a, input logic [7:0] e, input string tag);
    @(negedge clk); bus_addr = a; bus_rd = 1'b1;
    exp_q.push_back(e); tag_q.push_back(tag);
    @(negedge clk); bus_rd = 1'b0;
  endtask

  task automatic settle();
    repeat (2) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R10 reset state
    check("R10 host_irq", host_irq, 0);
    check("R10 card_irq", card_irq, 0);
    check("R10 win/dma", {win_en, dma_sel}, 0);
    check("R10 selects", {tf_cs, alt_cs}, 0);
    rd(14'h0000, 8'h00, "R10 ctrl reset");
    // R6 identity bits, code 3
    rd(14'h2280, 8'h01, "R6 id bit0");
    rd(14'h2284, 8'h01, "R6 id bit1");
    rd(14'h2288, 8'h00, "R6 id bit2");
    rd(14'h228C, 8'h00, "R6 id bit3");
    // R4/R5 raw status with latches disarmed
    drv_irq = 2'b01;
    settle();
    check("R5 card_irq", card_irq, 1);
    check("R3 gated off", host_irq, 0);
    rd(14'h2290, 8'h01, "R4 stat ch0");
    rd(14'h3290, 8'h00, "R4 stat ch1");
    // R1 arm ch0 with arbitrary data
    wr(14'h2200, 8'hA5);
    settle();
    check("R1 R3 ch0 armed", host_irq, 2'b01);
    drv_irq = 2'b10;
    settle();
    check("R3 ch0 req gone", host_irq, 2'b00);
    rd(14'h3290, 8'h01, "R4 stat ch1 raw");
    wr(14'h3200, 8'h00);
    settle();
    check("R1 ch1 armed", host_irq, 2'b10);
    // R2 disarm ch0 by read
    rd(14'h2200, 8'h00, "R2 disarm reads zero");
    drv_irq = 2'b11;
    settle();
    check("R2 ch0 disarmed", host_irq, 2'b10);
    check("R5 both", card_irq, 1);
    rd(14'h2290, 8'h01, "R4 raw while disarmed");
    rd(14'h3200, 8'h00, "R2 disarm ch1");
    settle();
    check("R2 ch1 disarmed", host_irq, 2'b00);
    // R11 near-miss write does not arm
    wr(14'h2204, 8'hFF);
    settle();
    check("R11 no arm", host_irq, 2'b00);
    rd(14'h2010, 8'h00, "R11 unmapped read");
    drv_irq = 2'b00;
    settle();
    check("R5 none", card_irq, 0);
    // R7 control byte
    wr(14'h0000, 8'h21);
    @(negedge clk);
    check("R7 win/dma set", {win_en, dma_sel}, 2'b11);
    rd(14'h0000, 8'h21, "R7 readback");
    wr(14'h0000, 8'h20);
    @(negedge clk);
    check("R7 dma ch0", {win_en, dma_sel}, 2'b10);
    wr(14'h0000, 8'h00);
    @(negedge clk);
    check("R7 cleared", {win_en, dma_sel}, 2'b00);
    // R8 task-file selects
    @(negedge clk); bus_addr = 14'h2140; bus_rd = 1'b1;
    exp_q.push_back(8'h00); tag_q.push_back("R8 tf read data");
    @(negedge clk); bus_rd = 1'b0;
    check("R8 tf ch0 reg5", {tf_cs, tf_reg}, {2'b01, 3'd5});
    @(negedge clk); bus_addr = 14'h31C0; bus_wr = 1'b1;
    @(negedge clk); bus_wr = 1'b0;
    check("R8 tf ch1 reg7", {tf_cs, tf_reg}, {2'b10, 3'd7});
    @(negedge clk);
    check("R8 one-cycle pulse", tf_cs, 2'b00);
    @(negedge clk); bus_addr = 14'h2010; bus_wr = 1'b1;
    @(negedge clk); bus_wr = 1'b0;
    check("R11 misaligned no cs", {tf_cs, alt_cs}, 0);
    // R9 alternate selects
    @(negedge clk); bus_addr = 14'h2380; bus_wr = 1'b1;
    @(negedge clk); bus_wr = 1'b0;
    check("R9 alt ch0", {alt_cs, tf_cs}, 4'b0100);
    @(negedge clk); bus_addr = 14'h3380; bus_wr = 1'b1;
    @(negedge clk); bus_wr = 1'b0;
    check("R9 alt ch1", {alt_cs, tf_cs}, 4'b1000);
    settle();
    check("scoreboard drained", exp_q.size(), 0);
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual hung expected done");
      end
    join_any
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule